// File: doc/BRIEF.md
# Mixed-Width Interval Timer Bank

This block holds four timers behind one simple 32-bit register bus. Three of them are reloading down-counters that can raise interrupts: two are 16 bits wide and one is 32 bits wide. Each has a load register, a live value register, a control register and a clear register. Each counts on either a slow or a fast tick strobe, as its control register selects. When a down-counter passes zero, it either reloads from its load register or wraps to all ones. It also sets a level interrupt, which stays high until software writes its clear register.

The fourth timer is a 40-bit up-counter that runs freely from a third tick strobe and never interrupts. Software reads its lower 32 bits from one register and its upper byte from a second register. The second register also holds the bit that starts and stops the counter. The tick strobes come from outside the block as one-cycle enables on the system clock.

Top module: `timer_bank`

## Requirements
- R1: After reset, all load, value and control registers read as zero, all three interrupt outputs are low, and the free counter is stopped at zero.
- R2: A write to a down-timer's load register (offset +0x0) sets both the load value and the live count at once. A read strobe returns data on `bus_rdata` one cycle later. The value register (offset +0x4) reads the live count.
- R3: While control bit 7 is 1, a down-timer's count drops by one on each selected tick. While bit 7 is 0, the count holds.
- R4: Control bit 3 selects the fast tick when 1 and the slow tick when 0. The unselected strobe leaves the count unchanged.
- R5: With control bit 6 set to 1, a selected tick at count zero reloads the count from the load register.
- R6: With control bit 6 set to 0, a selected tick at count zero wraps the count to all ones: 0xFFFF for the 16-bit timers and 0xFFFFFFFF for the 32-bit timer.
- R7: A selected tick at count zero sets that timer's interrupt (`irq[0]`, `irq[1]`, `irq[2]` for the timers at 0x00, 0x20, 0x80). The interrupt stays high until any value is written to that timer's clear register (offset +0xC). If a clear and an underflow happen in the same cycle, the underflow wins.
- R8: The three down-timers sit at bases 0x00, 0x20 and 0x80. The control register (offset +0x8) reads back only bits 7, 6 and 3; all its other bits read as zero.
- R9: The timers at 0x00 and 0x20 keep only the low 16 bits of a load write and read back zero-extended. The timer at 0x80 keeps all 32 bits.
- R10: Writing bit 8 of register 0x64 starts (1) or stops (0) the free counter. A 0-to-1 change clears the count to zero. While running, the count rises by one on each free tick; while stopped, it holds. 0x60 reads count bits 31:0. 0x64 reads count bits 39:32 in bits 7:0 and the run bit in bit 8. The free counter never drives any interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow | input | 1 | Slow tick enable for the down-timers |
| tick_fast | input | 1 | Fast tick enable for the down-timers |
| tick_free | input | 1 | Tick enable for the free counter |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_re` |
| irq | output | 3 | Level interrupts of the three down-timers |

## Verification
The bench builds the block with its default parameters: 16-bit short timers, a 32-bit long timer, a 40-bit free counter and an 8-bit address. Both wrap cases are reachable in a few ticks when a timer is loaded near zero, so the all-ones values 0xFFFF and 0xFFFFFFFF are checked directly. The carry into the free counter's upper byte would take 2^32 ticks, which is out of reach. That byte is therefore checked only for its zero value, for its position beside the run bit, and for the restart-to-zero rule.

// File: rtl/tbank_pkg.sv
package tbank_pkg;
  // register offsets inside one down-timer block
  localparam int OFS_LOAD = 'h0;
  localparam int OFS_VAL  = 'h4;
  localparam int OFS_CTRL = 'h8;
  localparam int OFS_CLR  = 'hC;
  // free counter registers
  localparam int FREE_LO  = 'h60;
  localparam int FREE_HI  = 'h64;
  // control bit positions
  localparam int CB_RUN   = 7;
  localparam int CB_RELD  = 6;
  localparam int CB_FAST  = 3;
  localparam int HI_RUN   = 8;

  localparam int NUM_DOWN = 3;

  function automatic int block_base(input int idx);
    case (idx)
      0:       return 'h00;
      1:       return 'h20;
      default: return 'h80;
    endcase
  endfunction
endpackage

// File: rtl/down_timer.sv
module down_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_slow,
  input  logic         tick_fast,
  input  logic         ld_we,
  input  logic         ctl_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [2:0]   ctl_in,   // {run, reload, fast}
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] load_o,
  output logic [2:0]   ctl_o,
  output logic         irq_o
);
  logic run, reld, fast;
  logic tick_sel, step, under;

  assign ctl_o    = {run, reld, fast};
  assign tick_sel = fast ? tick_fast : tick_slow;
  assign step     = run && tick_sel;
  assign under    = step && !ld_we && (cnt_o == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      load_o <= '0;
      run    <= 1'b0;
      reld   <= 1'b0;
      fast   <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (ctl_we) begin
        run  <= ctl_in[2];
        reld <= ctl_in[1];
        fast <= ctl_in[0];
      end
      if (ld_we) begin
        load_o <= wdata;
        cnt_o  <= wdata;
      end else if (step) begin
        if (cnt_o == '0) cnt_o <= reld ? load_o : '1;
        else             cnt_o <= cnt_o - 1'b1;
      end
      if (under)       irq_o <= 1'b1;
      else if (clr_we) irq_o <= 1'b0;
    end
  end

  // R3: no selected tick while running and no load -> count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!(run && tick_sel) && !ld_we) |=> $stable(cnt_o));

  // R5: periodic underflow reloads from the load register
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (run && tick_sel && !ld_we && cnt_o == '0 && reld) |=> (cnt_o == $past(load_o)));

  // R7: a pending interrupt persists until a clear write
  a_r7_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr_we) |=> irq_o);

  // R7: an underflow always leaves the interrupt set
  a_r7_under_wins: assert property (@(posedge clk) disable iff (rst)
    (run && tick_sel && !ld_we && cnt_o == '0) |=> irq_o);
endmodule

// File: rtl/free_counter.sv
module free_counter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         hi_we,
  input  logic         run_wr,
  output logic [W-1:0] cnt_o,
  output logic         run_o
);
  logic start;
  assign start = hi_we && run_wr && !run_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      run_o <= 1'b0;
    end else begin
      if (hi_we) run_o <= run_wr;
      if (start)              cnt_o <= '0;
      else if (run_o && tick) cnt_o <= cnt_o + 1'b1;
    end
  end

  // R10: a start from the stopped state yields zero
  a_r10_start_zero: assert property (@(posedge clk) disable iff (rst)
    (hi_we && run_wr && !run_o) |=> (cnt_o == '0));

  // R10: stopped and not starting -> count holds
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_o && !(hi_we && run_wr)) |=> $stable(cnt_o));

  // R10: running tick without restart increments by one
  a_r10_up: assert property (@(posedge clk) disable iff (rst)
    (run_o && tick && !hi_we) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import tbank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 32,
  parameter int FREE_W  = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_slow,
  input  logic                tick_fast,
  input  logic                tick_free,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_DOWN-1:0] irq
);
  localparam int HI_W = FREE_W - 32;

  logic [31:0] t_load [NUM_DOWN];
  logic [31:0] t_cnt  [NUM_DOWN];
  logic [2:0]  t_ctl  [NUM_DOWN];

  genvar g;
  generate
    for (g = 0; g < NUM_DOWN; g++) begin : g_down
      localparam int TW = (g == NUM_DOWN - 1) ? LONG_W : SHORT_W;
      localparam int BA = block_base(g);
      logic [TW-1:0] cnt_w, load_w;
      logic ld_we, ctl_we, clr_we;

      assign ld_we  = bus_we && (bus_addr == ADDR_W'(BA + OFS_LOAD));
      assign ctl_we = bus_we && (bus_addr == ADDR_W'(BA + OFS_CTRL));
      assign clr_we = bus_we && (bus_addr == ADDR_W'(BA + OFS_CLR));

      down_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .tick_slow(tick_slow),
        .tick_fast(tick_fast),
        .ld_we    (ld_we),
        .ctl_we   (ctl_we),
        .clr_we   (clr_we),
        .wdata    (bus_wdata[TW-1:0]),
        .ctl_in   ({bus_wdata[CB_RUN], bus_wdata[CB_RELD], bus_wdata[CB_FAST]}),
        .cnt_o    (cnt_w),
        .load_o   (load_w),
        .ctl_o    (t_ctl[g]),
        .irq_o    (irq[g])
      );

      assign t_cnt[g]  = 32'(cnt_w);
      assign t_load[g] = 32'(load_w);
    end
  endgenerate

  logic [FREE_W-1:0] f_cnt;
  logic              f_run;
  logic              f_hi_we;
  logic [31:0]       f_hi_word;

  assign f_hi_we = bus_we && (bus_addr == ADDR_W'(FREE_HI));

  free_counter #(.W(FREE_W)) u_free (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_free),
    .hi_we (f_hi_we),
    .run_wr(bus_wdata[HI_RUN]),
    .cnt_o (f_cnt),
    .run_o (f_run)
  );

  always_comb begin
    f_hi_word = '0;
    f_hi_word[HI_W-1:0] = f_cnt[FREE_W-1:32];
    f_hi_word[HI_RUN]   = f_run;
  end

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_DOWN; i++) begin
      if (bus_addr == ADDR_W'(block_base(i) + OFS_LOAD)) rd_next = t_load[i];
      if (bus_addr == ADDR_W'(block_base(i) + OFS_VAL))  rd_next = t_cnt[i];
      if (bus_addr == ADDR_W'(block_base(i) + OFS_CTRL))
        rd_next = {24'b0, t_ctl[i][2], t_ctl[i][1], 2'b00, t_ctl[i][0], 3'b000};
    end
    if (bus_addr == ADDR_W'(FREE_LO)) rd_next = f_cnt[31:0];
    if (bus_addr == ADDR_W'(FREE_HI)) rd_next = f_hi_word;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end

  // R1: interrupts are low in the cycle after reset
  a_r1_irq_idle: assert property (@(posedge clk)
    rst |=> (irq == '0));

  // R8: the control word never shows bits outside 7, 6 and 3
  a_r8_ctl_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == ADDR_W'(OFS_CTRL)) |=> ((bus_rdata & 32'hFFFF_FF37) == 32'h0));
endmodule

// File: tb/sim_timer_bank.sv
`timescale 1ns/1ps
module sim_timer_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_slow = 1'b0, tick_fast = 1'b0, tick_free = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  timer_bank u0 (
    .clk(clk), .rst(rst), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .tick_free(tick_free), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_slow(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_slow = 1'b1;
      @(negedge clk); tick_slow = 1'b0;
    end
  endtask

  task automatic pulse_fast(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_fast = 1'b1;
      @(negedge clk); tick_fast = 1'b0;
    end
  endtask

  task automatic pulse_free(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_free = 1'b1;
      @(negedge clk); tick_free = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R1 irq", 32'(irq), 0);
    rd(8'h00, rv); check("R1 t1 load", rv, 0);
    rd(8'h04, rv); check("R1 t1 value", rv, 0);
    rd(8'h08, rv); check("R1 t1 ctrl", rv, 0);
    rd(8'h84, rv); check("R1 t3 value", rv, 0);
    rd(8'h60, rv); check("R1 free lo", rv, 0);
    rd(8'h64, rv); check("R1 free hi", rv, 0);
  endtask

  task automatic t_load_count;
    wr(8'h00, 32'h0001_2345);
    rd(8'h00, rv); check("R9 t1 load truncated", rv, 32'h2345);
    rd(8'h04, rv); check("R2 t1 value after load", rv, 32'h2345);
    wr(8'h08, 32'h0000_00C0);
    rd(8'h08, rv); check("R8 t1 ctrl readback", rv, 32'hC0);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, rv); check("R8 t2 ctrl masked", rv, 32'hC8);
    wr(8'h28, 32'h0);
    pulse_slow(3);
    rd(8'h04, rv); check("R3 t1 three ticks", rv, 32'h2342);
    wr(8'h08, 32'h40);
    pulse_slow(2);
    rd(8'h04, rv); check("R3 t1 disabled hold", rv, 32'h2342);
    wr(8'h80, 32'hDEAD_BEEF);
    rd(8'h84, rv); check("R9 t3 full width", rv, 32'hDEAD_BEEF);
  endtask

  task automatic t_clksel;
    wr(8'h20, 32'd10);
    wr(8'h28, 32'h88);
    pulse_slow(4);
    rd(8'h24, rv); check("R4 slow ignored", rv, 32'd10);
    pulse_fast(3);
    rd(8'h24, rv); check("R4 fast counts", rv, 32'd7);
    wr(8'h28, 32'h0);
  endtask

  task automatic t_periodic;
    wr(8'h00, 32'd2);
    wr(8'h08, 32'hC0);
    pulse_slow(2);
    rd(8'h04, rv); check("R5 reached zero", rv, 0);
    check("R7 no irq before underflow", 32'(irq), 0);
    pulse_slow(1);
    rd(8'h04, rv); check("R5 reloaded", rv, 32'd2);
    check("R7 irq set", 32'(irq), 32'b001);
    pulse_slow(1);
    check("R7 irq held", 32'(irq), 32'b001);
    rd(8'h04, rv); check("R5 counting after reload", rv, 32'd1);
    wr(8'h0C, 32'h0000_DEAD);
    check("R7 clear any value", 32'(irq), 0);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_wrap;
    wr(8'h80, 32'd1);
    wr(8'h88, 32'h80);
    pulse_slow(2);
    rd(8'h84, rv); check("R6 t3 wrap", rv, 32'hFFFF_FFFF);
    check("R7 t3 irq", 32'(irq), 32'b100);
    wr(8'h88, 32'h0);
    wr(8'h8C, 32'h0);
    wr(8'h20, 32'd0);
    wr(8'h28, 32'h88);
    pulse_fast(1);
    rd(8'h24, rv); check("R6 t2 wrap 16", rv, 32'h0000_FFFF);
    check("R7 t2 irq", 32'(irq), 32'b010);
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h1);
    check("R7 t2 cleared", 32'(irq), 0);
  endtask

  task automatic t_clear_race;
    wr(8'h00, 32'd0);
    wr(8'h08, 32'hC0);
    @(negedge clk);
    bus_addr = 8'h0C; bus_wdata = 32'h5; bus_we = 1'b1; tick_slow = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_slow = 1'b0;
    check("R7 underflow beats clear", 32'(irq), 32'b001);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h0);
    check("R7 clear after race", 32'(irq), 0);
  endtask

  task automatic t_free;
    pulse_free(3);
    rd(8'h60, rv); check("R10 stopped holds", rv, 0);
    wr(8'h64, 32'h100);
    pulse_free(5);
    rd(8'h60, rv); check("R10 counts up", rv, 32'd5);
    rd(8'h64, rv); check("R10 hi word", rv, 32'h100);
    wr(8'h64, 32'h100);
    pulse_free(2);
    rd(8'h60, rv); check("R10 rewrite no restart", rv, 32'd7);
    wr(8'h64, 32'h0);
    pulse_free(3);
    rd(8'h60, rv); check("R10 stop holds", rv, 32'd7);
    rd(8'h64, rv); check("R10 hi stopped", rv, 32'h0);
    wr(8'h64, 32'h100);
    rd(8'h60, rv); check("R10 restart zero", rv, 0);
    check("R10 no irq", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_count();
    t_clksel();
    t_periodic();
    t_wrap();
    t_clear_race();
    t_free();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule